// File: doc/BRIEF.md
# Speculative Load Conflict Tracker

This block keeps a small associative record of loads that were issued early, ahead of stores that might alias them. Each early load leaves an entry behind, tagged with the number of its destination register and the 8-byte line and byte lanes it read. Every store is snooped against all entries, and any entry whose bytes overlap the store's bytes is dropped. When the program later reaches the point where the load would have run, it looks the register up. A surviving entry means no conflicting store came in between, so the early value is good. A missing entry means speculation failed.

There are three independent ports. The insert port takes early loads, including the deferred form that carries a pending fault. The snoop port takes stores. The check port performs lookups. A lookup is either a reload-style check or a branch-style check. A branch-style check asks for recovery code when it misses. Either kind may also clear the entry it looked up. The check result comes back from a register on the cycle after the request. The load datapath, the branch to recovery code and the cache sit outside this block.

Top module: `adv_load_tracker`

## Requirements
- R1: After reset no entry is valid. Every check misses, and `rsp_valid` stays low until a check is issued.
- R2: An insert of register r stores r's tag. A check of r issued on any later cycle hits if no store, clear or replacement has removed it. A check of a register that was never inserted misses.
- R3: The size code selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Accesses are naturally aligned, so address bits below the size are ignored. Address bits [2:0] pick the byte lane, and the bits above pick the 8-byte line. A store removes every entry in the same line whose byte range overlaps the store's. Entries in another line, or on disjoint lanes of the same line, stay.
- R4: `chk_kind` 0 is a reload check, which never raises `rsp_recover`. `chk_kind` 1 is a branch check, which raises `rsp_recover` exactly when it misses. `rsp_recover` and `rsp_hit` are never high together.
- R5: A check with `chk_clear` high reports the lookup result and then removes the entry, so the next check of that register misses.
- R6: An insert for a register that already has an entry overwrites that entry, so at most one entry exists per register. Only the newest address is then protected.
- R7: An insert with `ins_deferred` high allocates no entry and removes any existing entry for that register. A later check of that register misses.
- R8: New registers take slots in round-robin order starting at slot 0 after reset. After ENTRIES+1 distinct registers have been inserted, the first one misses and all the others hit.
- R9: A store and a check in the same cycle are ordered store first. A check whose entry that store overlaps misses.
- R10: `rsp_valid`, `rsp_hit` and `rsp_recover` appear on the cycle after `chk_valid`. `rsp_valid` is high only on that cycle.
- R11: An insert takes effect on the next cycle. A check in the same cycle sees the table as it was before the insert. A store in the same cycle as an insert does not remove the newly inserted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Early load insert request |
| ins_reg | input | REG_W | Destination register of the early load |
| ins_addr | input | ADDR_W | Byte address of the early load |
| ins_size | input | 2 | Size code of the early load |
| ins_deferred | input | 1 | Load carries a deferred fault; no entry is allocated |
| st_valid | input | 1 | Store snoop request |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | Size code of the store |
| chk_valid | input | 1 | Lookup request |
| chk_reg | input | REG_W | Register to look up |
| chk_kind | input | 1 | 0 reload check, 1 branch check |
| chk_clear | input | 1 | Remove the entry after the lookup |
| rsp_valid | output | 1 | Lookup result is valid |
| rsp_hit | output | 1 | Entry was present |
| rsp_recover | output | 1 | Branch check missed; recovery is required |

## Verification
On every cycle, the assertions check these properties:
- A killed or cleared slot is empty on the next cycle.
- A written slot holds the new tag.
- No lookup matches more than one slot.
- A response follows each check exactly one cycle later.
- A hit and a recovery request never appear together.
- The victim pointer stays in range and moves only when a new slot is taken.

Only the bench scenarios can show the following:
- The byte-overlap arithmetic, swept over every lane and size pair of an insert and a store.
- The round-robin eviction order.
- The effect of deferred and replacing inserts.
- The ordering rules between stores, checks and inserts that arrive in the same cycle.

// File: rtl/adv_load_pkg.sv
package adv_load_pkg;

  localparam int unsigned LANES      = 8;
  localparam int unsigned LANE_BITS  = 3;

  typedef logic [LANES-1:0] lane_mask_t;

  typedef enum logic {
    CHK_RELOAD = 1'b0,
    CHK_BRANCH = 1'b1
  } chk_kind_e;

  // Byte lanes touched by a naturally aligned access of 1, 2, 4 or 8 bytes.
  function automatic lane_mask_t lane_mask(input logic [2:0] off, input logic [1:0] size);
    lane_mask_t span;
    logic [2:0] base;
    case (size)
      2'd0: begin span = 8'h01; base = off;                 end
      2'd1: begin span = 8'h03; base = {off[2:1], 1'b0};    end
      2'd2: begin span = 8'h0F; base = {off[2], 2'b00};     end
      default: begin span = 8'hFF; base = 3'b000;           end
    endcase
    return lane_mask_t'(span << base);
  endfunction

endpackage

// File: rtl/ldtrk_overlap.sv
module ldtrk_overlap
  import adv_load_pkg::*;
#(
  parameter int LINE_W = 45
) (
  input  logic [LINE_W-1:0] ent_line,
  input  lane_mask_t        ent_mask,
  input  logic [LINE_W-1:0] snp_line,
  input  lane_mask_t        snp_mask,
  output logic              conflict
);

  logic same_line;
  logic lanes_shared;

  always_comb begin
    same_line    = (ent_line == snp_line);
    lanes_shared = |(ent_mask & snp_mask);
    conflict     = same_line && lanes_shared;
  end

endmodule

// File: rtl/ldtrk_victim.sv
module ldtrk_victim #(
  parameter int ENTRIES = 32,
  parameter int PTR_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST) else $error("victim pointer out of range"); // R8

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q)) else $error("victim pointer moved without allocation"); // R8

endmodule

// File: rtl/ldtrk_slot.sv
module ldtrk_slot
  import adv_load_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int LINE_W = 45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              kill,
  input  logic [REG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  lane_mask_t        wr_mask,
  output logic              vld,
  output logic [REG_W-1:0]  tag,
  output logic [LINE_W-1:0] line,
  output lane_mask_t        mask
);

  logic              vld_q, vld_d;
  logic [REG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;
  lane_mask_t        mask_q;
  logic              vld_en;

  always_comb begin
    vld_en = wr_en || kill;
    vld_d  = vld_q;
    if (wr_en) begin
      vld_d = 1'b1;
    end else if (kill) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (vld_en) begin
      vld_q <= vld_d;
    end
  end

  // Payload needs no reset: it is qualified by vld_q.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q  <= wr_tag;
      line_q <= wr_line;
      mask_q <= wr_mask;
    end
  end

  assign vld  = vld_q;
  assign tag  = tag_q;
  assign line = line_q;
  assign mask = mask_q;

  AST_KILL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    kill && !wr_en |=> !vld_q) else $error("killed slot still valid"); // R5

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q && (tag_q == $past(wr_tag))) else $error("written slot wrong"); // R2

endmodule

// File: rtl/adv_load_tracker.sv
module adv_load_tracker
  import adv_load_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [1:0]        ins_size,
  input  logic              ins_deferred,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_kind,
  input  logic              chk_clear,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_recover
);

  localparam int LINE_W = ADDR_W - LANE_BITS;
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Decoded request fields
  logic [LINE_W-1:0] ins_line, st_line;
  lane_mask_t        ins_mask, st_mask;

  always_comb begin
    ins_line = ins_addr[ADDR_W-1:LANE_BITS];
    st_line  = st_addr[ADDR_W-1:LANE_BITS];
    ins_mask = lane_mask(ins_addr[LANE_BITS-1:0], ins_size);
    st_mask  = lane_mask(st_addr[LANE_BITS-1:0], st_size);
  end

  // Per-slot state and match vectors
  logic [ENTRIES-1:0] ent_vld;
  logic [REG_W-1:0]   ent_tag  [ENTRIES];
  logic [LINE_W-1:0]  ent_line [ENTRIES];
  lane_mask_t         ent_mask [ENTRIES];

  logic [ENTRIES-1:0] ins_tag_hit;
  logic [ENTRIES-1:0] chk_tag_hit;
  logic [ENTRIES-1:0] st_conflict;
  logic [ENTRIES-1:0] st_hit;
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] kill;

  logic [PTR_W-1:0]   victim;
  logic               any_ins_tag;
  logic               alloc_new;
  logic               ins_live;
  logic               ins_defer;
  logic               chk_found;

  always_comb begin
    ins_live    = ins_valid && !ins_deferred;
    ins_defer   = ins_valid && ins_deferred;
    any_ins_tag = |ins_tag_hit;
    alloc_new   = ins_live && !any_ins_tag;
    // Store is ordered before the check: a slot it kills cannot hit.
    chk_found   = |(chk_tag_hit & ~st_hit);
  end

  ldtrk_victim #(
    .ENTRIES (ENTRIES),
    .PTR_W   (PTR_W)
  ) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (alloc_new),
    .ptr   (victim)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic victim_here;

    ldtrk_overlap #(
      .LINE_W (LINE_W)
    ) u_ovl (
      .ent_line (ent_line[i]),
      .ent_mask (ent_mask[i]),
      .snp_line (st_line),
      .snp_mask (st_mask),
      .conflict (st_conflict[i])
    );

    always_comb begin
      victim_here    = (victim == PTR_W'(i));
      ins_tag_hit[i] = ent_vld[i] && (ent_tag[i] == ins_reg);
      chk_tag_hit[i] = ent_vld[i] && (ent_tag[i] == chk_reg);
      st_hit[i]      = st_valid && ent_vld[i] && st_conflict[i];
      wr_sel[i]      = ins_live && (any_ins_tag ? ins_tag_hit[i] : victim_here);
      kill[i]        = st_hit[i]
                     || (chk_valid && chk_clear && chk_tag_hit[i])
                     || (ins_defer && ins_tag_hit[i]);
    end

    ldtrk_slot #(
      .REG_W  (REG_W),
      .LINE_W (LINE_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_sel[i]),
      .kill    (kill[i]),
      .wr_tag  (ins_reg),
      .wr_line (ins_line),
      .wr_mask (ins_mask),
      .vld     (ent_vld[i]),
      .tag     (ent_tag[i]),
      .line    (ent_line[i]),
      .mask    (ent_mask[i])
    );

    AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
      st_hit[i] && !wr_sel[i] |=> !ent_vld[i]) else $error("overlapping store left entry"); // R3

    AST_DEFER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ins_defer && ins_tag_hit[i] |=> !ent_vld[i]) else $error("deferred insert kept entry"); // R7
  end

  // Registered check response
  logic rsp_valid_q, rsp_hit_q, rsp_recover_q;
  logic rsp_hit_d,   rsp_recover_d;

  always_comb begin
    rsp_hit_d     = chk_valid && chk_found;
    rsp_recover_d = chk_valid && !chk_found && (chk_kind == CHK_BRANCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q   <= 1'b0;
      rsp_hit_q     <= 1'b0;
      rsp_recover_q <= 1'b0;
    end else begin
      rsp_valid_q   <= chk_valid;
      rsp_hit_q     <= rsp_hit_d;
      rsp_recover_q <= rsp_recover_d;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_hit     = rsp_hit_q;
  assign rsp_recover = rsp_recover_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid) else $error("missing response"); // R10

  AST_RSP_ONLY_AFTER_CHK: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !rsp_valid && !rsp_hit && !rsp_recover) else $error("spurious response"); // R10

  AST_HIT_XOR_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_recover)) else $error("hit and recover together"); // R4

  AST_ONE_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $onehot0(chk_tag_hit)) else $error("duplicate register entries"); // R6

  AST_STORE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && |(chk_tag_hit & st_hit) |=> !rsp_hit) else $error("check hit past store"); // R9

endmodule

// File: tb/adv_load_tracker_test.sv
module adv_load_tracker_test;

  localparam int ENTRIES = 32;
  localparam int REG_W   = 7;
  localparam int ADDR_W  = 48;
  localparam int WDOG    = 150000;

  logic              clk;
  logic              rst_n;
  logic              ins_valid, ins_deferred, st_valid, chk_valid, chk_kind, chk_clear;
  logic [REG_W-1:0]  ins_reg, chk_reg;
  logic [ADDR_W-1:0] ins_addr, st_addr;
  logic [1:0]        ins_size, st_size;
  logic              rsp_valid, rsp_hit, rsp_recover;

  int tests_run = 0;
  int tests_failed = 0;
  logic cap_valid, cap_hit, cap_recover;

  adv_load_tracker #(
    .ENTRIES (ENTRIES),
    .REG_W   (REG_W),
    .ADDR_W  (ADDR_W)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .ins_reg      (ins_reg),
    .ins_addr     (ins_addr),
    .ins_size     (ins_size),
    .ins_deferred (ins_deferred),
    .st_valid     (st_valid),
    .st_addr      (st_addr),
    .st_size      (st_size),
    .chk_valid    (chk_valid),
    .chk_reg      (chk_reg),
    .chk_kind     (chk_kind),
    .chk_clear    (chk_clear),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_recover  (rsp_recover)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic idle_inputs();
    ins_valid = 0; ins_reg = '0; ins_addr = '0; ins_size = '0; ins_deferred = 0;
    st_valid = 0; st_addr = '0; st_size = '0;
    chk_valid = 0; chk_reg = '0; chk_kind = 0; chk_clear = 0;
  endtask

  task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // One cycle: inputs driven after the falling edge, response captured just after the rising edge.
  task automatic cycle(
    input logic iv, input logic [REG_W-1:0] ir, input logic [ADDR_W-1:0] ia, input logic [1:0] isz, input logic idf,
    input logic sv, input logic [ADDR_W-1:0] sa, input logic [1:0] ssz,
    input logic cv, input logic [REG_W-1:0] cr, input logic ck, input logic cc);
    @(negedge clk);
    ins_valid = iv; ins_reg = ir; ins_addr = ia; ins_size = isz; ins_deferred = idf;
    st_valid = sv; st_addr = sa; st_size = ssz;
    chk_valid = cv; chk_reg = cr; chk_kind = ck; chk_clear = cc;
    @(posedge clk);
    #1;
    cap_valid = rsp_valid; cap_hit = rsp_hit; cap_recover = rsp_recover;
    idle_inputs();
  endtask

  task automatic do_ins(input logic [REG_W-1:0] r, input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic df);
    cycle(1, r, a, sz, df, 0, '0, 0, 0, '0, 0, 0);
  endtask

  task automatic do_st(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    cycle(0, '0, '0, 0, 0, 1, a, sz, 0, '0, 0, 0);
  endtask

  task automatic do_chk(input logic [REG_W-1:0] r, input logic k, input logic c);
    cycle(0, '0, '0, 0, 0, 0, '0, 0, 1, r, k, c);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic ranges_overlap(input int ioff, input int isz, input int soff, input int ssz);
    int ilo, ihi, slo, shi;
    ilo = ioff & ~((1 << isz) - 1);
    ihi = ilo + (1 << isz);
    slo = soff & ~((1 << ssz) - 1);
    shi = slo + (1 << ssz);
    return (ilo < shi) && (slo < ihi);
  endfunction

  logic done = 1'b0;

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin : main
    logic [ADDR_W-1:0] base;
    idle_inputs();
    rst_n = 0;
    do_reset();

    // R1: empty after reset, no response without a check
    cycle(0, '0, '0, 0, 0, 0, '0, 0, 0, '0, 0, 0);
    expect_bit("R1", "rsp_valid idle", cap_valid, 1'b0);
    for (int r = 0; r < 4; r++) begin
      do_chk(REG_W'(r * 17), 1, 0);
      expect_bit("R1", "hit after reset", cap_hit, 1'b0);
      expect_bit("R1", "recover after reset", cap_recover, 1'b1);
    end

    // R2 / R10: insert then check
    do_ins(7'd10, 48'h0000_0000_1000, 2'd3, 0);
    do_chk(7'd10, 0, 0);
    expect_bit("R10", "rsp_valid after check", cap_valid, 1'b1);
    expect_bit("R2", "hit inserted reg", cap_hit, 1'b1);
    cycle(0, '0, '0, 0, 0, 0, '0, 0, 0, '0, 0, 0);
    expect_bit("R10", "rsp_valid drops", cap_valid, 1'b0);
    do_chk(7'd11, 0, 0);
    expect_bit("R2", "other reg misses", cap_hit, 1'b0);
    expect_bit("R4", "reload check no recover", cap_recover, 1'b0);

    // R4: branch check on present and missing
    do_chk(7'd10, 1, 0);
    expect_bit("R4", "branch hit no recover", cap_recover, 1'b0);
    do_chk(7'd12, 1, 0);
    expect_bit("R4", "branch miss recovers", cap_recover, 1'b1);
    expect_bit("R4", "branch miss no hit", cap_hit, 1'b0);

    // R5: clearing check
    do_chk(7'd10, 1, 1);
    expect_bit("R5", "clear reports hit", cap_hit, 1'b1);
    do_chk(7'd10, 0, 0);
    expect_bit("R5", "cleared entry misses", cap_hit, 1'b0);

    // R3: exhaustive lane/size sweep within one line
    base = 48'h0000_0000_2000;
    for (int io = 0; io < 8; io++) begin
      for (int is = 0; is < 4; is++) begin
        for (int so = 0; so < 8; so++) begin
          for (int ss = 0; ss < 4; ss++) begin
            do_ins(7'd5, base | ADDR_W'(io), 2'(is), 0);
            do_st(base | ADDR_W'(so), 2'(ss));
            do_chk(7'd5, 0, 0);
            expect_bit("R3", $sformatf("overlap i%0d/%0d s%0d/%0d", io, is, so, ss),
                       cap_hit, !ranges_overlap(io, is, so, ss));
          end
        end
      end
    end
    // R3: other lines never conflict
    do_ins(7'd6, 48'h0000_0000_3000, 2'd3, 0);
    do_st(48'h0000_0000_3008, 2'd3);
    do_st(48'h0000_0000_2FF8, 2'd3);
    do_chk(7'd6, 0, 0);
    expect_bit("R3", "neighbour lines keep entry", cap_hit, 1'b1);

    // R6: replace keeps one entry, new address protected
    do_ins(7'd20, 48'h0000_0000_4000, 2'd3, 0);
    do_ins(7'd20, 48'h0000_0000_5000, 2'd3, 0);
    do_st(48'h0000_0000_4000, 2'd3);
    do_chk(7'd20, 0, 0);
    expect_bit("R6", "old address no longer tracked", cap_hit, 1'b1);
    do_st(48'h0000_0000_5004, 2'd2);
    do_chk(7'd20, 0, 0);
    expect_bit("R6", "new address tracked", cap_hit, 1'b0);

    // R7: deferred insert
    do_ins(7'd30, 48'h0000_0000_6000, 2'd3, 1);
    do_chk(7'd30, 1, 0);
    expect_bit("R7", "deferred alone misses", cap_hit, 1'b0);
    do_ins(7'd31, 48'h0000_0000_6100, 2'd3, 0);
    do_ins(7'd31, 48'h0000_0000_6200, 2'd3, 1);
    do_chk(7'd31, 1, 0);
    expect_bit("R7", "deferred drops existing", cap_recover, 1'b1);

    // R9: store and check same cycle
    do_ins(7'd40, 48'h0000_0000_7000, 2'd2, 0);
    cycle(0, '0, '0, 0, 0, 1, 48'h0000_0000_7002, 2'd0, 1, 7'd40, 1, 0);
    expect_bit("R9", "store-first miss", cap_hit, 1'b0);
    expect_bit("R9", "store-first recover", cap_recover, 1'b1);

    // R11: insert with same-cycle check and store
    cycle(1, 7'd41, 48'h0000_0000_8000, 2'd3, 0, 1, 48'h0000_0000_8000, 2'd3, 1, 7'd41, 0, 0);
    expect_bit("R11", "same-cycle check sees old state", cap_hit, 1'b0);
    do_chk(7'd41, 0, 0);
    expect_bit("R11", "insert survives same-cycle store", cap_hit, 1'b1);

    // R8: round-robin eviction from a fresh table
    do_reset();
    for (int r = 0; r <= ENTRIES; r++) begin
      do_ins(REG_W'(r), ADDR_W'(48'h10000 + r * 64), 2'd3, 0);
    end
    do_chk(7'd0, 1, 0);
    expect_bit("R8", "oldest evicted", cap_recover, 1'b1);
    for (int r = 1; r <= ENTRIES; r++) begin
      do_chk(REG_W'(r), 0, 0);
      expect_bit("R8", $sformatf("reg %0d retained", r), cap_hit, 1'b1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule